// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Zero and Carry Flags

This block is the combinational arithmetic and logic stage of an 8-bit accumulator machine. An operation code selects one of the following: an 8-bit add, subtract or compare; a bitwise operation; a complement or negate of the accumulator; or a 16-bit add on a register pair. The block returns the new accumulator value and a write strobe for it. On the 16-bit path it returns the new pair value and a separate strobe. It also returns the zero and carry flags to be stored.

The surrounding core owns the accumulator, the register pairs and the flag register. It presents the current values on the inputs and latches the outputs when the matching strobe is high. Compare and the unused codes leave the accumulator untouched. Complement leaves both flags as they came in. Each operation class follows its own carry rule.

Top module: `alu8_flags_unit`

## Requirements
- R1: With op 1 (add-with-carry) the result is (acc + opnd + carry_i) mod 256 and wr_o is 1. carry_o is 1 exactly when the true sum exceeds 255. zero_o is 1 exactly when the 8-bit result is 0. Op 0 (add) follows the same rules with the carry term taken as 0.
- R2: Op 0 (add) ignores carry_i: the result and both flags are the same whatever carry_i is.
- R3: Op 2 (subtract) gives acc - opnd mod 256. Op 3 (subtract-with-borrow) gives acc - opnd - carry_i mod 256. Both set wr_o. carry_o is 1 exactly when the subtrahend plus any borrow-in is greater than acc as unsigned values. zero_o follows the 8-bit result.
- R4: Op 4 (compare) sets zero_o when acc equals opnd and sets carry_o when opnd is greater than acc. It ignores carry_i, holds wr_o at 0 and shows acc on res_o.
- R5: Comparing the accumulator with an equal operand always gives zero_o 1 and carry_o 0, whatever carry_i is.
- R6: Ops 5, 6 and 7 (AND, OR, XOR) write the bitwise result, clear carry_o and set zero_o from the result.
- R7: Op 8 (complement) writes the bitwise inverse of acc. zero_o and carry_o equal zero_i and carry_i.
- R8: Op 9 (negate) writes (0 - acc) mod 256. zero_o follows the result, and carry_o is 1 exactly when acc is nonzero.
- R9: Op 10 (16-bit add) gives pair_a + pair_b mod 65536. Op 11 (16-bit add-with-carry) also adds carry_i. Both raise wide_wr_o and set carry_o when the true sum exceeds 65535. Op 10 passes zero_i through to zero_o, while op 11 sets zero_o from the 16-bit result.
- R10: Codes 12 to 15 pass acc to res_o with wr_o and wide_wr_o at 0 and both flags unchanged.
- R11: At most one of wr_o and wide_wr_o is high. res_o equals acc whenever wr_o is low, and wide_res_o equals pair_a_i whenever wide_wr_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (0 to 11 defined, 12 to 15 pass-through) |
| acc_i | input | 8 | Current accumulator value |
| opnd_i | input | 8 | Second 8-bit operand |
| pair_a_i | input | 16 | Destination register pair value for 16-bit adds |
| pair_b_i | input | 16 | Source register pair value for 16-bit adds |
| carry_i | input | 1 | Current carry flag |
| zero_i | input | 1 | Current zero flag |
| res_o | output | 8 | New accumulator value |
| wr_o | output | 1 | Accumulator write strobe |
| wide_res_o | output | 16 | New register pair value |
| wide_wr_o | output | 1 | Register pair write strobe |
| zero_o | output | 1 | Zero flag to store |
| carry_o | output | 1 | Carry flag to store |

## Verification
The immediate checks inside the unit assume that every input is a driven binary value while they are evaluated. No check applies any meaning to the values of inputs that the selected operation does not use. The stimulus drives all seven inputs to known values from time zero and changes them only away from the sampling point. Every code from 0 to 15 is exercised, including the undefined upper codes, so all decode branches run with defined operands.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    parameter int unsigned DATA_W = 8;
    localparam int unsigned WIDE_W = 2 * DATA_W;
    localparam int unsigned OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_CMP  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_CPL  = 4'd8,
        OP_NEG  = 4'd9,
        OP_ADDW = 4'd10,
        OP_ADCW = 4'd11
    } alu_op_e;

    typedef enum logic [1:0] {
        BW_AND = 2'd0,
        BW_OR  = 2'd1,
        BW_XOR = 2'd2,
        BW_INV = 2'd3
    } bw_sel_e;

    typedef struct packed {
        logic zero;
        logic carry;
    } flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic              acc_we;
        logic [WIDE_W-1:0] pair;
        logic              pair_we;
        flags_t            flg;
    } alu_out_t;

    function automatic logic is_narrow_arith(input logic [OP_W-1:0] op);
        return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
               (op == OP_SBC) || (op == OP_CMP) || (op == OP_NEG);
    endfunction

    function automatic logic is_bitwise(input logic [OP_W-1:0] op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

    function automatic logic is_wide(input logic [OP_W-1:0] op);
        return (op == OP_ADDW) || (op == OP_ADCW);
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    localparam int unsigned EXT_W = W + 1;

    logic [EXT_W-1:0] ext;
    logic [EXT_W-1:0] cin_ext;

    always_comb begin
        cin_ext = {{W{1'b0}}, cin_i};
        if (sub_i) begin
            ext = {1'b0, a_i} - {1'b0, b_i} - cin_ext;
        end else begin
            ext = {1'b0, a_i} + {1'b0, b_i} + cin_ext;
        end
    end

    assign sum_o  = ext[W-1:0];
    assign cout_o = ext[W];
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  bw_sel_e      sel_i,
    output logic [W-1:0] y_o
);
    always_comb begin
        unique case (sel_i)
            BW_AND:  y_o = a_i & b_i;
            BW_OR:   y_o = a_i | b_i;
            BW_XOR:  y_o = a_i ^ b_i;
            default: y_o = ~a_i;
        endcase
    end
endmodule

// File: rtl/alu8_flags_unit.sv
module alu8_flags_unit
    import alu8_pkg::*;
(
    input  logic [3:0]  op_i,
    input  logic [7:0]  acc_i,
    input  logic [7:0]  opnd_i,
    input  logic [15:0] pair_a_i,
    input  logic [15:0] pair_b_i,
    input  logic        carry_i,
    input  logic        zero_i,
    output logic [7:0]  res_o,
    output logic        wr_o,
    output logic [15:0] wide_res_o,
    output logic        wide_wr_o,
    output logic        zero_o,
    output logic        carry_o
);
    // Narrow arithmetic operand steering
    logic [DATA_W-1:0] ar_a, ar_b, ar_sum, bw_y;
    logic              ar_cin, ar_sub, ar_cout;
    logic [WIDE_W-1:0] wd_sum;
    logic              wd_cin, wd_cout;
    bw_sel_e           bw_sel;
    alu_out_t          o;

    always_comb begin
        ar_a   = (op_i == OP_NEG) ? '0 : acc_i;
        ar_b   = (op_i == OP_NEG) ? acc_i : opnd_i;
        ar_cin = ((op_i == OP_ADC) || (op_i == OP_SBC)) ? carry_i : 1'b0;
        ar_sub = (op_i == OP_SUB) || (op_i == OP_SBC) ||
                 (op_i == OP_CMP) || (op_i == OP_NEG);
        wd_cin = (op_i == OP_ADCW) ? carry_i : 1'b0;
        case (op_i)
            OP_OR:   bw_sel = BW_OR;
            OP_XOR:  bw_sel = BW_XOR;
            OP_CPL:  bw_sel = BW_INV;
            default: bw_sel = BW_AND;
        endcase
    end

    alu8_addsub #(.W(DATA_W)) u_narrow (
        .a_i   (ar_a),
        .b_i   (ar_b),
        .cin_i (ar_cin),
        .sub_i (ar_sub),
        .sum_o (ar_sum),
        .cout_o(ar_cout)
    );

    alu8_addsub #(.W(WIDE_W)) u_wide (
        .a_i   (pair_a_i),
        .b_i   (pair_b_i),
        .cin_i (wd_cin),
        .sub_i (1'b0),
        .sum_o (wd_sum),
        .cout_o(wd_cout)
    );

    alu8_bitwise #(.W(DATA_W)) u_bits (
        .a_i  (acc_i),
        .b_i  (opnd_i),
        .sel_i(bw_sel),
        .y_o  (bw_y)
    );

    // Result and flag selection per operation class
    always_comb begin
        o.acc       = acc_i;
        o.acc_we    = 1'b0;
        o.pair      = pair_a_i;
        o.pair_we   = 1'b0;
        o.flg.zero  = zero_i;
        o.flg.carry = carry_i;
        if (is_narrow_arith(op_i)) begin
            o.flg.zero  = (ar_sum == '0);
            o.flg.carry = ar_cout;
            if (op_i != OP_CMP) begin
                o.acc    = ar_sum;
                o.acc_we = 1'b1;
            end
        end else if (is_bitwise(op_i)) begin
            o.acc       = bw_y;
            o.acc_we    = 1'b1;
            o.flg.zero  = (bw_y == '0);
            o.flg.carry = 1'b0;
        end else if (op_i == OP_CPL) begin
            o.acc    = bw_y;
            o.acc_we = 1'b1;
        end else if (is_wide(op_i)) begin
            o.pair      = wd_sum;
            o.pair_we   = 1'b1;
            o.flg.carry = wd_cout;
            if (op_i == OP_ADCW) begin
                o.flg.zero = (wd_sum == '0);
            end
        end
    end

    assign res_o      = o.acc;
    assign wr_o       = o.acc_we;
    assign wide_res_o = o.pair;
    assign wide_wr_o  = o.pair_we;
    assign zero_o     = o.flg.zero;
    assign carry_o    = o.flg.carry;

    // Checks against port-level relations
    always_comb begin
        assert_one_strobe_R11: assert ($onehot0({wr_o, wide_wr_o}));
        if (!wr_o) begin
            assert_acc_hold_R11: assert (res_o == acc_i);
        end
        if (op_i == OP_CMP) begin
            assert_cmp_no_write_R4: assert (!wr_o && !wide_wr_o);
            if (acc_i == opnd_i) begin
                assert_cmp_self_R5: assert (zero_o && !carry_o);
            end
        end
        if (is_bitwise(op_i)) begin
            assert_bitwise_carry_clear_R6: assert (!carry_o && (zero_o == (res_o == 8'h00)));
        end
        if (op_i == OP_CPL) begin
            assert_cpl_flags_keep_R7: assert (zero_o == zero_i && carry_o == carry_i);
        end
        if (op_i >= 4'd12) begin
            assert_pass_through_R10: assert (!wr_o && !wide_wr_o &&
                                             zero_o == zero_i && carry_o == carry_i);
        end
    end
endmodule

// File: tb/alu8_flags_unit_tb.sv
module alu8_flags_unit_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [3:0]  op_i = 4'd12;
    logic [7:0]  acc_i = 8'h00, opnd_i = 8'h00;
    logic [15:0] pair_a_i = 16'h0000, pair_b_i = 16'h0000;
    logic        carry_i = 1'b0, zero_i = 1'b0;
    logic [7:0]  res_o;
    logic        wr_o, wide_wr_o, zero_o, carry_o;
    logic [15:0] wide_res_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    alu8_flags_unit u_dut (
        .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
        .pair_a_i(pair_a_i), .pair_b_i(pair_b_i),
        .carry_i(carry_i), .zero_i(zero_i),
        .res_o(res_o), .wr_o(wr_o), .wide_res_o(wide_res_o),
        .wide_wr_o(wide_wr_o), .zero_o(zero_o), .carry_o(carry_o)
    );

    // op, acc, opnd, cin, zin | res, wr, z, c
    localparam int NV = 25;
    localparam logic [32:0] VEC [NV] = '{
        {4'd0, 8'h10, 8'h20, 1'b1, 1'b0, 8'h30, 1'b1, 1'b0, 1'b0}, // R2
        {4'd0, 8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1}, // R1
        {4'd1, 8'hFF, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1}, // R1
        {4'd1, 8'h12, 8'h34, 1'b1, 1'b1, 8'h47, 1'b1, 1'b0, 1'b0}, // R1
        {4'd1, 8'h80, 8'h7F, 1'b0, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b0}, // R1
        {4'd2, 8'h50, 8'h20, 1'b1, 1'b1, 8'h30, 1'b1, 1'b0, 1'b0}, // R3
        {4'd2, 8'h20, 8'h50, 1'b0, 1'b0, 8'hD0, 1'b1, 1'b0, 1'b1}, // R3
        {4'd3, 8'h20, 8'h1F, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0}, // R3
        {4'd3, 8'h20, 8'h20, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b1}, // R3
        {4'd4, 8'h42, 8'h42, 1'b1, 1'b0, 8'h42, 1'b0, 1'b1, 1'b0}, // R4
        {4'd4, 8'h10, 8'h11, 1'b0, 1'b1, 8'h10, 1'b0, 1'b0, 1'b1}, // R4
        {4'd4, 8'h11, 8'h10, 1'b1, 1'b1, 8'h11, 1'b0, 1'b0, 1'b0}, // R4
        {4'd5, 8'hF0, 8'h0F, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0}, // R6
        {4'd5, 8'hF3, 8'h3C, 1'b1, 1'b1, 8'h30, 1'b1, 1'b0, 1'b0}, // R6
        {4'd6, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0}, // R6
        {4'd6, 8'hA0, 8'h05, 1'b1, 1'b1, 8'hA5, 1'b1, 1'b0, 1'b0}, // R6
        {4'd7, 8'h5A, 8'h5A, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0}, // R6
        {4'd7, 8'h5A, 8'hFF, 1'b1, 1'b1, 8'hA5, 1'b1, 1'b0, 1'b0}, // R6
        {4'd8, 8'h3C, 8'h00, 1'b1, 1'b0, 8'hC3, 1'b1, 1'b0, 1'b1}, // R7
        {4'd8, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0}, // R7
        {4'd9, 8'h01, 8'h00, 1'b0, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b1}, // R8
        {4'd9, 8'h00, 8'h55, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0}, // R8
        {4'd9, 8'h80, 8'h00, 1'b0, 1'b1, 8'h80, 1'b1, 1'b0, 1'b1}, // R8
        {4'd12, 8'h77, 8'h11, 1'b1, 1'b0, 8'h77, 1'b0, 1'b0, 1'b1}, // R10
        {4'd15, 8'h00, 8'hFF, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0}  // R10
    };

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0:           return "R2";
            4'd1:           return "R1";
            4'd2, 4'd3:     return "R3";
            4'd4:           return "R4";
            4'd5, 4'd6, 4'd7: return "R6";
            4'd8:           return "R7";
            4'd9:           return "R8";
            default:        return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [15:0] pa, input logic [15:0] pb,
                         input logic ci, input logic zi);
        @(posedge clk);
        #1;
        op_i = op; acc_i = a; opnd_i = b; pair_a_i = pa; pair_b_i = pb;
        carry_i = ci; zero_i = zi;
        @(negedge clk);
    endtask

    task automatic wide_case(input logic [3:0] op, input logic [15:0] pa,
                             input logic [15:0] pb, input logic ci, input logic zi,
                             input logic [15:0] e_res, input logic e_z, input logic e_c);
        apply(op, 8'h3A, 8'h00, pa, pb, ci, zi);
        check("R9", "wide result", wide_res_o, e_res);
        check("R9", "wide strobe", {15'd0, wide_wr_o}, 16'd1);
        check("R9", "zero", {15'd0, zero_o}, {15'd0, e_z});
        check("R9", "carry", {15'd0, carry_o}, {15'd0, e_c});
        check("R11", "acc strobe low", {15'd0, wr_o}, 16'd0);
        check("R11", "acc held", {8'd0, res_o}, 16'h003A);
    endtask

    initial begin
        // Idle state: pass-through code with all-zero inputs (R10)
        apply(4'd12, 8'h00, 8'h00, 16'h0000, 16'h0000, 1'b0, 1'b0);
        check("R10", "idle res", {8'd0, res_o}, 16'h0000);
        check("R10", "idle strobes", {14'd0, wr_o, wide_wr_o}, 16'd0);
        check("R10", "idle flags", {14'd0, zero_o, carry_o}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            logic [32:0] v;
            v = VEC[i];
            apply(v[32:29], v[28:21], v[20:13], 16'hBEEF, 16'h1234, v[12], v[11]);
            check(req_of(v[32:29]), "res",   {8'd0, res_o},      {8'd0, v[10:3]});
            check(req_of(v[32:29]), "wr",    {15'd0, wr_o},      {15'd0, v[2]});
            check(req_of(v[32:29]), "zero",  {15'd0, zero_o},    {15'd0, v[1]});
            check(req_of(v[32:29]), "carry", {15'd0, carry_o},   {15'd0, v[0]});
            check("R11", "pair held", wide_res_o, 16'hBEEF);
            check("R11", "pair strobe low", {15'd0, wide_wr_o}, 16'd0);
        end

        // R2: add with carry_i toggled gives identical outcome
        apply(4'd0, 8'h80, 8'h80, 16'h0, 16'h0, 1'b1, 1'b0);
        check("R2", "add ignores cin res", {8'd0, res_o}, 16'h0000);
        check("R2", "add ignores cin flags", {14'd0, zero_o, carry_o}, 16'b11);

        // R5: equal compare under both carry inputs
        for (int c = 0; c < 2; c++) begin
            apply(4'd4, 8'hC7, 8'hC7, 16'h0, 16'h0, c[0], 1'b0);
            check("R5", "self compare flags", {14'd0, zero_o, carry_o}, 16'b10);
            check("R5", "self compare no write", {15'd0, wr_o}, 16'd0);
        end

        // R9: 16-bit adds
        wide_case(4'd10, 16'hFFFF, 16'h0001, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1);
        wide_case(4'd10, 16'h1234, 16'h1111, 1'b1, 1'b1, 16'h2345, 1'b1, 1'b0);
        wide_case(4'd11, 16'hFFFF, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b1);
        wide_case(4'd11, 16'h1000, 16'h0FFF, 1'b1, 1'b1, 16'h2000, 1'b0, 1'b0);

        // R10: remaining unused codes
        for (int k = 13; k < 15; k++) begin
            apply(k[3:0], 8'h9C, 8'h01, 16'h0, 16'h0, 1'b1, 1'b1);
            check("R10", "pass res", {8'd0, res_o}, 16'h009C);
            check("R10", "pass strobes/flags", {12'd0, wr_o, wide_wr_o, zero_o, carry_o}, 16'b0011);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule